// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps a small direct-mapped private cache coherent with its peers on a shared snooping bus. Each line carries a tag, one data word and a four-valued coherence state: Invalid, Shared, Exclusive or Modified. Processor reads and writes are served locally when the line's state allows it. Otherwise the controller issues a bus request and waits for a grant. The possible requests are a plain read, a read-for-ownership that invalidates other copies, and a writeback of a dirty victim.

Transactions that other agents place on the bus arrive on the snoop inputs. Within the same cycle the controller answers them. It raises a shared indication when it holds the addressed line valid during a snooped read. It also supplies the line's data on a flush output when its copy is dirty. The line state is then demoted at the next clock edge. The requester samples the peers' shared indication during its own read grant, and this chooses Exclusive or Shared for the filled line.

The request machine has four states. IDLE accepts a processor request when no snoop is present in that cycle. Hits go to DONE. A miss whose victim is dirty goes to EVICT, and any other miss goes to FILL. EVICT issues the writeback and moves to FILL after its grant. It also moves to FILL with no bus request when a snoop has already cleaned the victim. FILL issues a read or read-for-ownership and writes the line on grant, then goes to DONE. DONE pulses completion for one cycle and returns to IDLE. Only one bus transaction is outstanding at a time. A bus transaction is granted and completes within a single cycle, and the arbiter never grants this cache in a cycle that carries a snoop.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_done` are low, and `cpu_done` never stays high for two cycles in a row.
- R2: A read miss issues one read command (`bus_cmd` 2'b01) for the request address and returns the granted `bus_rdata` on `cpu_rdata`; with `bus_shared_in` low at the grant the line becomes Exclusive.
- R3: A read miss with `bus_shared_in` high at the grant leaves the line Shared, so a later write to it issues a read-for-ownership.
- R4: A write to an Exclusive line completes with no bus command and leaves the line Modified.
- R5: A write to a Shared line issues exactly one read-for-ownership (`bus_cmd` 2'b10) and then leaves the line Modified holding the written word.
- R6: A write miss issues one read-for-ownership and no read, and the line then holds the written word in Modified.
- R7: Reads and writes to a Modified line complete with no bus command, and reads return the latest written word.
- R8: A snooped read (`snp_cmd` 2'b01) that hits a valid line asserts `snp_shared` in that cycle. A Modified hit also asserts `snp_flush` with the line's word. A Modified or Exclusive line becomes Shared.
- R9: A snooped read-for-ownership (`snp_cmd` 2'b10) that hits asserts `snp_flush` with the word when the line is Modified, never asserts `snp_shared`, and leaves the line Invalid.
- R10: A snooped writeback (`snp_cmd` 2'b11), and any snoop whose tag differs from the stored tag, produce no shared or flush response and leave the line unchanged.
- R11: A miss whose victim is Modified first issues a writeback (`bus_cmd` 2'b11) carrying the victim's address and word, and only then the fill. A clean victim causes no writeback.
- R12: A snoop arriving between a local request and its grant takes effect first. If it demotes a dirty victim, no writeback is issued. If it invalidates a Shared line awaiting ownership, the fill still completes with the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 writeback |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_wdata | output | DATA_W | Writeback word |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill word, valid with the grant |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with the grant |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line during a snooped read |
| snp_flush | output | 1 | This cache is supplying dirty data |
| snp_data | output | DATA_W | Flushed word |

## Verification
The hardest situation to reach is a snoop that arrives after the controller has committed to a miss but before the arbiter grants it. Examples are a snooped read that cleans the dirty victim during the eviction wait, or a snooped read-for-ownership that takes away a Shared line during the ownership wait. The bench's bus model holds back the grant on the first cycle it sees `bus_req` and drives the chosen snoop in that cycle instead. It then grants normally. The bench checks the flushed word, the absence of a writeback and the final data of the line. Each intermediate state is otherwise confirmed through later traffic, such as whether a following write is silent or issues a read-for-ownership.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    localparam logic [1:0] CMD_NONE = 2'd0;
    localparam logic [1:0] CMD_RD   = 2'd1;
    localparam logic [1:0] CMD_RDX  = 2'd2;
    localparam logic [1:0] CMD_WB   = 2'd3;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_EVICT = 2'd1,
        F_FILL  = 2'd2,
        F_DONE  = 2'd3
    } req_fsm_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_t          wr_st,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dat_en,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_t          st_w   [LINES];
    logic [TAG_W-1:0]  tag_w  [LINES];
    logic [DATA_W-1:0] data_w [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_t          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)   st_r <= ST_I;
            else if (sel) st_r <= wr_st;
        end

        always_ff @(posedge clk) begin
            if (sel && wr_tag_en) tag_r  <= wr_tag;
            if (sel && wr_dat_en) data_r <= wr_data;
        end

        assign st_w[g]   = st_r;
        assign tag_w[g]  = tag_r;
        assign data_w[g] = data_r;
    end

    assign a_st   = st_w[a_idx];
    assign a_tag  = tag_w[a_idx];
    assign a_data = data_w[a_idx];
    assign b_st   = st_w[b_idx];
    assign b_tag  = tag_w[b_idx];
    assign b_data = data_w[b_idx];

endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_data,
    output logic              upd_en,
    output line_st_t          upd_st
);

    logic hit;

    always_comb begin
        hit        = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        shared_o   = 1'b0;
        flush_o    = 1'b0;
        upd_en     = 1'b0;
        upd_st     = line_st;
        flush_data = line_data;
        if (hit) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    shared_o = 1'b1;
                    flush_o  = (line_st == ST_M);
                    upd_en   = 1'b1;
                    upd_st   = ST_S;
                end
                CMD_RDX: begin
                    flush_o  = (line_st == ST_M);
                    upd_en   = 1'b1;
                    upd_st   = ST_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    req_fsm_t          fsm_q, fsm_d;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              take;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    line_st_t          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              a_hit;

    logic              loc_we, loc_tag_en, loc_dat_en;
    line_st_t          loc_st;
    logic [DATA_W-1:0] loc_data;

    logic              s_upd_en;
    line_st_t          s_upd_st;

    logic              wr_en, wr_tag_en, wr_dat_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_t          wr_st;

    assign cur_addr = (fsm_q == F_IDLE) ? cpu_addr : rq_addr;
    assign cur_idx  = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    assign a_hit    = (a_st != ST_I) && (a_tag == cur_tag);

    mesi_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cur_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
        .wr_tag_en(wr_tag_en), .wr_tag(cur_tag),
        .wr_dat_en(wr_dat_en), .wr_data(loc_data)
    );

    mesi_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .line_st(b_st), .line_tag(b_tag), .line_data(b_data),
        .shared_o(snp_shared), .flush_o(snp_flush), .flush_data(snp_data),
        .upd_en(s_upd_en), .upd_st(s_upd_st)
    );

    // Snoop updates take the single write port; local writes never coincide.
    always_comb begin
        if (s_upd_en) begin
            wr_en = 1'b1;  wr_idx = snp_addr[IDX_W-1:0];  wr_st = s_upd_st;
            wr_tag_en = 1'b0;  wr_dat_en = 1'b0;
        end else begin
            wr_en = loc_we;  wr_idx = cur_idx;  wr_st = loc_st;
            wr_tag_en = loc_tag_en;  wr_dat_en = loc_dat_en;
        end
    end

    // Next-state and array update process
    always_comb begin
        fsm_d      = fsm_q;
        take       = 1'b0;
        rdata_d    = rdata_q;
        loc_we     = 1'b0;
        loc_tag_en = 1'b0;
        loc_dat_en = 1'b0;
        loc_st     = a_st;
        loc_data   = cpu_wdata;
        unique case (fsm_q)
            F_IDLE: if (cpu_req && !snp_valid) begin
                take = 1'b1;
                if (a_hit && (!cpu_we || a_st == ST_E || a_st == ST_M)) begin
                    if (cpu_we) begin
                        loc_we     = 1'b1;
                        loc_st     = ST_M;
                        loc_dat_en = 1'b1;
                        rdata_d    = cpu_wdata;
                    end else begin
                        rdata_d = a_data;
                    end
                    fsm_d = F_DONE;
                end else if (a_st == ST_M && a_tag != cur_tag) begin
                    fsm_d = F_EVICT;
                end else begin
                    fsm_d = F_FILL;
                end
            end
            F_EVICT: begin
                if (a_st != ST_M) begin
                    fsm_d = F_FILL;
                end else if (bus_gnt) begin
                    loc_we = 1'b1;
                    loc_st = ST_I;
                    fsm_d  = F_FILL;
                end
            end
            F_FILL: if (bus_gnt) begin
                loc_we     = 1'b1;
                loc_tag_en = 1'b1;
                loc_dat_en = 1'b1;
                loc_data   = rq_we ? rq_wdata : bus_rdata;
                loc_st     = rq_we ? ST_M : (bus_shared_in ? ST_S : ST_E);
                rdata_d    = loc_data;
                fsm_d      = F_DONE;
            end
            F_DONE: fsm_d = F_IDLE;
            default: fsm_d = F_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q    <= F_IDLE;
            rq_we    <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rdata_q  <= '0;
        end else begin
            fsm_q   <= fsm_d;
            rdata_q <= rdata_d;
            if (take) begin
                rq_we    <= cpu_we;
                rq_addr  <= cpu_addr;
                rq_wdata <= cpu_wdata;
            end
        end
    end

    // Output process
    always_comb begin
        cpu_done  = (fsm_q == F_DONE);
        cpu_rdata = rdata_q;
        bus_req   = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_addr  = rq_addr;
        bus_wdata = a_data;
        unique case (fsm_q)
            F_EVICT: if (a_st == ST_M) begin
                bus_req  = 1'b1;
                bus_cmd  = CMD_WB;
                bus_addr = {a_tag, cur_idx};
            end
            F_FILL: begin
                bus_req = 1'b1;
                bus_cmd = rq_we ? CMD_RDX : CMD_RD;
            end
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R1
    AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd != CMD_WB) |=> cpu_done); // R2
    AST_FLUSH_FROM_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (b_st == ST_M)); // R8
    AST_SHARED_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_cmd == CMD_RD)); // R9
    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == CMD_WB) |=> (bus_req && bus_cmd != CMD_WB)); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> bus_req); // R12
    AST_NO_GNT_WITH_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_gnt)); // R12

endmodule

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_shared_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [15:0] snp_addr = '0;
    logic        snp_shared, snp_flush;
    logic [31:0] snp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    int total = 0, bad = 0;
    int n_rd, n_rdx, n_wb;
    logic [15:0] wb_addr;
    logic [31:0] wb_data, op_rdata;
    logic        inj_flush;
    logic [31:0] inj_data;
    logic        s_sh, s_fl;
    logic [31:0] s_dat;
    logic [31:0] mem [logic [15:0]];

    function automatic logic [31:0] memrd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : {a, ~a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] wd,
                          input logic sh, input logic inj, input logic [1:0] icmd,
                          input logic [15:0] iaddr);
        logic fin = 1'b0;
        n_rd = 0; n_rdx = 0; n_wb = 0; inj_flush = 1'b0; inj_data = '0;
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1; bus_shared_in = sh;
        while (!fin) begin
            @(negedge clk);
            bus_gnt = 1'b0;
            snp_valid = 1'b0;
            if (cpu_done) begin
                op_rdata = cpu_rdata;
                cpu_req = 1'b0;
                fin = 1'b1;
            end else if (bus_req) begin
                if (inj) begin
                    inj = 1'b0;
                    snp_valid = 1'b1; snp_cmd = icmd; snp_addr = iaddr;
                    #1;
                    inj_flush = snp_flush; inj_data = snp_data;
                    if (snp_flush) mem[iaddr] = snp_data;
                end else begin
                    case (bus_cmd)
                        C_RD:  n_rd++;
                        C_RDX: n_rdx++;
                        C_WB:  begin n_wb++; wb_addr = bus_addr; wb_data = bus_wdata;
                                     mem[bus_addr] = bus_wdata; end
                        default: ;
                    endcase
                    bus_rdata = memrd(bus_addr);
                    bus_gnt = 1'b1;
                end
            end
        end
    endtask

    task automatic snoop(input logic [1:0] c, input logic [15:0] a);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        s_sh = snp_shared; s_fl = snp_flush; s_dat = snp_data;
        if (snp_flush) mem[a] = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 bus_req after reset", 32'(bus_req), 0);
        chk("R1 cpu_done after reset", 32'(cpu_done), 0);
        cpu_op(0, 16'h0031, 0, 0, 0, 0, 0);
        chk("R1 first read misses", n_rd, 1);
    endtask

    task automatic t_exclusive;
        chk("R2 read miss data", op_rdata, memrd(16'h0031));
        cpu_op(1, 16'h0031, 32'hA1A1_0001, 0, 0, 0, 0);
        chk("R4 E write silent", n_rd + n_rdx + n_wb, 0);
        cpu_op(0, 16'h0031, 0, 0, 0, 0, 0);
        chk("R7 M read no bus", n_rd + n_rdx + n_wb, 0);
        chk("R7 M read data", op_rdata, 32'hA1A1_0001);
        cpu_op(1, 16'h0031, 32'hA1A1_0002, 0, 0, 0, 0);
        chk("R7 M write no bus", n_rd + n_rdx + n_wb, 0);
    endtask

    task automatic t_snoop_read_dirty;
        snoop(C_RD, 16'h0031);
        chk("R8 shared on M", 32'(s_sh), 1);
        chk("R8 flush on M", 32'(s_fl), 1);
        chk("R8 flush data", s_dat, 32'hA1A1_0002);
        cpu_op(1, 16'h0031, 32'hA1A1_0003, 0, 0, 0, 0);
        chk("R5 S write issues RDX", n_rdx, 1);
        chk("R5 S write no read", n_rd, 0);
        cpu_op(0, 16'h0031, 0, 0, 0, 0, 0);
        chk("R5 now M, data", op_rdata, 32'hA1A1_0003);
        chk("R5 now M, no bus", n_rd + n_rdx + n_wb, 0);
    endtask

    task automatic t_shared_fill;
        cpu_op(0, 16'h0042, 0, 1, 0, 0, 0);
        chk("R3 read miss data", op_rdata, memrd(16'h0042));
        cpu_op(1, 16'h0042, 32'hB2B2_0001, 0, 0, 0, 0);
        chk("R3 S write needs RDX", n_rdx, 1);
    endtask

    task automatic t_snoop_read_clean;
        cpu_op(0, 16'h0053, 0, 0, 0, 0, 0);
        snoop(C_RD, 16'h0053);
        chk("R8 shared on E", 32'(s_sh), 1);
        chk("R8 no flush on E", 32'(s_fl), 0);
        cpu_op(1, 16'h0053, 32'hC3C3_0001, 0, 0, 0, 0);
        chk("R8 E demoted to S", n_rdx, 1);
    endtask

    task automatic t_write_miss_and_rdx;
        cpu_op(1, 16'h0064, 32'hD4D4_0001, 0, 0, 0, 0);
        chk("R6 write miss RDX", n_rdx, 1);
        chk("R6 write miss no RD", n_rd, 0);
        cpu_op(0, 16'h0064, 0, 0, 0, 0, 0);
        chk("R6 data after write miss", op_rdata, 32'hD4D4_0001);
        chk("R6 line is M", n_rd + n_rdx + n_wb, 0);
        snoop(C_RDX, 16'h0064);
        chk("R9 flush on RDX", 32'(s_fl), 1);
        chk("R9 flush data", s_dat, 32'hD4D4_0001);
        chk("R9 no shared on RDX", 32'(s_sh), 0);
        cpu_op(0, 16'h0064, 0, 0, 0, 0, 0);
        chk("R9 line invalid", n_rd, 1);
        chk("R9 refetch data", op_rdata, 32'hD4D4_0001);
    endtask

    task automatic t_ignored_snoops;
        cpu_op(0, 16'h0075, 0, 0, 0, 0, 0);
        snoop(C_WB, 16'h0075);
        chk("R10 snooped WB no shared", 32'(s_sh), 0);
        chk("R10 snooped WB no flush", 32'(s_fl), 0);
        snoop(C_RD, 16'h1175);
        chk("R10 tag miss no shared", 32'(s_sh), 0);
        cpu_op(1, 16'h0075, 32'hE5E5_0001, 0, 0, 0, 0);
        chk("R10 line still E", n_rd + n_rdx + n_wb, 0);
    endtask

    task automatic t_eviction;
        cpu_op(1, 16'h0086, 32'hF6F6_0001, 0, 0, 0, 0);
        cpu_op(0, 16'h0186, 0, 0, 0, 0, 0);
        chk("R11 dirty victim WB", n_wb, 1);
        chk("R11 WB address", 32'(wb_addr), 32'h0086);
        chk("R11 WB data", wb_data, 32'hF6F6_0001);
        chk("R11 fill after WB", n_rd, 1);
        chk("R11 fill data", op_rdata, memrd(16'h0186));
        cpu_op(0, 16'h0286, 0, 0, 0, 0, 0);
        chk("R11 clean victim no WB", n_wb, 0);
    endtask

    task automatic t_snoop_before_grant;
        cpu_op(1, 16'h0097, 32'h1717_0001, 0, 0, 0, 0);
        cpu_op(0, 16'h0197, 0, 0, 1, C_RD, 16'h0097);
        chk("R12 victim flushed by snoop", 32'(inj_flush), 1);
        chk("R12 flushed word", inj_data, 32'h1717_0001);
        chk("R12 no WB after clean", n_wb, 0);
        chk("R12 fill done", op_rdata, memrd(16'h0197));
        cpu_op(0, 16'h00A8, 0, 1, 0, 0, 0);
        cpu_op(1, 16'h00A8, 32'h2828_0001, 0, 1, C_RDX, 16'h00A8);
        chk("R12 RDX after steal", n_rdx, 1);
        cpu_op(0, 16'h00A8, 0, 0, 0, 0, 0);
        chk("R12 data after steal", op_rdata, 32'h2828_0001);
        chk("R12 line owned", n_rd + n_rdx + n_wb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exclusive();
        t_snoop_read_dirty();
        t_shared_fill();
        t_snoop_read_clean();
        t_write_miss_and_rdx();
        t_ignored_snoops();
        t_eviction();
        t_snoop_before_grant();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule